// File: doc/BRIEF.md
# Interrupt Status Controller with Raise and Acknowledge Writes

This block keeps a 32-bit interrupt status word. Software sets bits by writing a value to a raise offset; the value is ORed into the word. Software clears bits by writing a mask to an acknowledge offset. Internal event sources, such as a transfer-complete strobe, can also set fixed bits with single-cycle pulses. The status word can be read back at its own offset.

The block signals the interrupt in one of two ways, selected by an enable input. In level mode, which is the default with the enable low, a line stays high for as long as any status bit is set. In message mode, the level line is held low. Instead, a single one-cycle pulse marks each change of the status word from zero to nonzero. Both modes use the same acknowledge write to clear the word, so a handler must acknowledge in either mode before a new message pulse can appear.

All state updates on the clock edge that samples a write or a pulse. The status word, the level line and the pulse are all registered, so they change together one cycle after the stimulus.

Top module: `intr_status_ctrl`

## Requirements
- R1: While reset is asserted and until the first write or event after it, the status read returns 0 and both `irq_level` and `msi_pulse` are 0.
- R2: A write with `wr_en` high at offset 0x60 ORs `wr_data` into the status word. The new value reads back at offset 0x24 in the cycle after the write edge.
- R3: A write with `wr_en` high at offset 0x64 clears every status bit that is 1 in `wr_data` and leaves the other bits unchanged.
- R4: If an event pulse sets a bit on the same edge as an acknowledge write that clears that bit, the bit stays set.
- R5: Event source 0 sets status bit 8 (value 0x100) and event source 1 sets status bit 0 (value 0x1). An event is ORed in together with a raise write on the same edge.
- R6: With `msi_en` low, `irq_level` is 1 exactly when the registered status is nonzero. It changes together with the status word.
- R7: With `msi_en` high, `irq_level` is 0. `msi_pulse` is 1 for exactly one cycle when the status word changes from zero to nonzero. No pulse follows a further raise while the word is already nonzero, and no pulse follows a switch of mode.
- R8: In message mode, status bits are cleared only by acknowledge writes. After the word has been acknowledged down to zero, the next raise or event produces a new pulse.
- R9: Writes with `wr_en` low, and writes to any offset other than 0x60 or 0x64 (including 0x24), leave the status unchanged. A read at any offset other than 0x24 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_off | input | 8 | Register read offset |
| rd_data | output | 32 | Read data: status at offset 0x24, otherwise 0 |
| evt_pulse | input | 2 | Internal event strobes, one cycle each |
| msi_en | input | 1 | 1 selects message signalling, 0 selects level |
| irq_level | output | 1 | Level interrupt line |
| msi_pulse | output | 1 | One-cycle message interrupt strobe |

## Verification
The assertions assume that each event input is a strobe sampled on one edge, and that a write carries a single offset. They also assume that `msi_en` is a quasi-static mode input, although the block tolerates a change at any edge. The bench changes every input only on the falling clock edge. It raises each event input for one cycle at a time, and changes `msi_en` only on cycles with no write pending, except in one deliberate mode-switch step. Event pulses coincide with raise and acknowledge writes only in the steps that exercise those same-edge cases.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned       OFF_W     = 8,
  parameter logic [OFF_W-1:0]  RAISE_OFF = 8'h60,
  parameter logic [OFF_W-1:0]  ACK_OFF   = 8'h64
) (
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  word_t            wr_data,
  output word_t            set_bits,
  output word_t            clr_bits
);
  logic hit_set, hit_clr;

  always_comb begin
    hit_set  = wr_en && (wr_off == RAISE_OFF);
    hit_clr  = wr_en && (wr_off == ACK_OFF);
    set_bits = hit_set ? wr_data : '0;
    clr_bits = hit_clr ? wr_data : '0;
  end
endmodule

// File: rtl/irqc_event_map.sv
module irqc_event_map
  import irqc_pkg::*;
#(
  parameter int unsigned                  NUM_EVT   = 2,
  parameter logic [NUM_EVT*WORD_W-1:0]    EVT_MASKS = {32'h0000_0001, 32'h0000_0100}
) (
  input  logic [NUM_EVT-1:0] evt_pulse,
  output word_t              evt_bits
);
  word_t term [NUM_EVT];

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_src
    assign term[g] = evt_pulse[g] ? EVT_MASKS[g*WORD_W +: WORD_W] : '0;
  end

  always_comb begin
    evt_bits = '0;
    for (int i = 0; i < NUM_EVT; i++) evt_bits = evt_bits | term[i];
  end
endmodule

// File: rtl/irqc_status_reg.sv
module irqc_status_reg
  import irqc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t set_bits,
  input  word_t clr_bits,
  input  word_t evt_bits,
  output word_t status_d,
  output word_t status_q
);
  logic  upd_en;
  word_t status_r;

  always_comb begin
    upd_en   = |{set_bits, clr_bits, evt_bits};
    // set sources win over a clear of the same bit
    status_d = (status_r & ~clr_bits) | set_bits | evt_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_r <= '0;
    else if (upd_en) status_r <= status_d;
  end

  assign status_q = status_r;
endmodule

// File: rtl/irqc_signal.sv
module irqc_signal
  import irqc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  msi_en,
  input  word_t status_q,
  input  word_t status_d,
  output logic  irq_level,
  output logic  msi_pulse
);
  logic lvl_d, lvl_q, pls_d, pls_q;
  logic now_set, next_set;

  always_comb begin
    now_set  = |status_q;
    next_set = |status_d;
    lvl_d    = !msi_en && next_set;
    pls_d    = msi_en && !now_set && next_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      pls_q <= pls_d;
    end
  end

  assign irq_level = lvl_q;
  assign msi_pulse = pls_q;
endmodule

// File: rtl/intr_status_ctrl.sv
module intr_status_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned               OFF_W     = 8,
  parameter logic [OFF_W-1:0]          RAISE_OFF = 8'h60,
  parameter logic [OFF_W-1:0]          ACK_OFF   = 8'h64,
  parameter logic [OFF_W-1:0]          STAT_OFF  = 8'h24,
  parameter int unsigned               NUM_EVT   = 2,
  parameter logic [NUM_EVT*WORD_W-1:0] EVT_MASKS = {32'h0000_0001, 32'h0000_0100}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [OFF_W-1:0]   wr_off,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [OFF_W-1:0]   rd_off,
  output logic [WORD_W-1:0]  rd_data,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               msi_en,
  output logic               irq_level,
  output logic               msi_pulse
);
  logic  rst_n_s;
  word_t set_bits, clr_bits, evt_bits, status_d, status_q;

  irqc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  irqc_decode #(.OFF_W(OFF_W), .RAISE_OFF(RAISE_OFF), .ACK_OFF(ACK_OFF)) u_dec (
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .set_bits(set_bits), .clr_bits(clr_bits)
  );

  irqc_event_map #(.NUM_EVT(NUM_EVT), .EVT_MASKS(EVT_MASKS)) u_evt (
    .evt_pulse(evt_pulse), .evt_bits(evt_bits)
  );

  irqc_status_reg u_stat (
    .clk(clk), .rst_n(rst_n_s), .set_bits(set_bits), .clr_bits(clr_bits),
    .evt_bits(evt_bits), .status_d(status_d), .status_q(status_q)
  );

  irqc_signal u_sig (
    .clk(clk), .rst_n(rst_n_s), .msi_en(msi_en), .status_q(status_q),
    .status_d(status_d), .irq_level(irq_level), .msi_pulse(msi_pulse)
  );

  always_comb rd_data = (rd_off == STAT_OFF) ? status_q : '0;
endmodule

// File: rtl/intr_status_ctrl_chk.sv
module intr_status_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int unsigned       OFF_W     = 8,
  parameter logic [OFF_W-1:0]  RAISE_OFF = 8'h60,
  parameter logic [OFF_W-1:0]  ACK_OFF   = 8'h64,
  parameter int unsigned       NUM_EVT   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [OFF_W-1:0]   wr_off,
  input logic [WORD_W-1:0]  wr_data,
  input logic [NUM_EVT-1:0] evt_pulse,
  input logic [WORD_W-1:0]  evt_bits,
  input logic               msi_en,
  input logic [WORD_W-1:0]  status,
  input logic               irq_level,
  input logic               msi_pulse
);
  logic raise_wr, ack_wr;
  assign raise_wr = wr_en && (wr_off == RAISE_OFF);
  assign ack_wr   = wr_en && (wr_off == ACK_OFF);

  assert_raise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    raise_wr |=> ((status & $past(wr_data)) == $past(wr_data)));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && evt_pulse == '0) |=> ((status & $past(wr_data)) == '0));

  assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((status & $past(evt_bits)) == $past(evt_bits)));

  assert_level_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level |-> (status != '0));

  assert_level_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |=> !irq_level);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |=> !msi_pulse);

  assert_pulse_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> (status != '0 && $past(status) == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!raise_wr && !ack_wr && evt_pulse == '0) |=> $stable(status));
endmodule

bind intr_status_ctrl intr_status_ctrl_chk #(
  .OFF_W(OFF_W), .RAISE_OFF(RAISE_OFF), .ACK_OFF(ACK_OFF), .NUM_EVT(NUM_EVT)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
  .evt_pulse(evt_pulse), .evt_bits(evt_bits), .msi_en(msi_en), .status(status_q),
  .irq_level(irq_level), .msi_pulse(msi_pulse)
);

// File: tb/sim_intr_status_ctrl.sv
`timescale 1ns/1ps
module sim_intr_status_ctrl;
  localparam logic [7:0] OFF_RAISE = 8'h60;
  localparam logic [7:0] OFF_ACK   = 8'h64;
  localparam logic [7:0] OFF_STAT  = 8'h24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_off;
  logic [31:0] wr_data;
  logic [7:0]  rd_off;
  logic [31:0] rd_data;
  logic [1:0]  evt_pulse;
  logic        msi_en;
  logic        irq_level;
  logic        msi_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] st;
    logic        lvl;
    logic        pls;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] m_status;

  always #5 clk = ~clk;

  intr_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .rd_off(rd_off), .rd_data(rd_data), .evt_pulse(evt_pulse), .msi_en(msi_en),
    .irq_level(irq_level), .msi_pulse(msi_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic we, input logic [7:0] off, input logic [31:0] d,
                      input logic [1:0] ev, input logic msi, input string tag);
    logic [31:0] setv, clrv, evv, nxt;
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_off = off; wr_data = d; evt_pulse = ev; msi_en = msi;
    setv = (we && off == OFF_RAISE) ? d : 32'h0;
    clrv = (we && off == OFF_ACK)   ? d : 32'h0;
    evv  = (ev[0] ? 32'h100 : 32'h0) | (ev[1] ? 32'h1 : 32'h0);
    nxt  = (m_status & ~clrv) | setv | evv;
    e.st  = nxt;
    e.lvl = !msi && (nxt != 0);
    e.pls = msi && (m_status == 0) && (nxt != 0);
    e.tag = tag;
    sb.push_back(e);
    m_status = nxt;
  endtask

  task automatic idle(input logic msi);
    step(1'b0, 8'h00, 32'h0, 2'b00, msi, "idle");
  endtask

  // monitor: pops one expectation per cycle after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " status"}, rd_data, e.st);
        chk({e.tag, " irq_level"}, {31'h0, irq_level}, {31'h0, e.lvl});
        chk({e.tag, " msi_pulse"}, {31'h0, msi_pulse}, {31'h0, e.pls});
      end
    end
  end

  task automatic read_at(input logic [7:0] off, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_off = off;
    #1 chk(tag, rd_data, exp);
    rd_off = OFF_STAT;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_off = 8'h0; wr_data = 32'h0;
    rd_off = OFF_STAT; evt_pulse = 2'b00; msi_en = 1'b0; m_status = 32'h0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset status", rd_data, 32'h0);
    chk("R1 reset irq_level", {31'h0, irq_level}, 32'h0);
    chk("R1 reset msi_pulse", {31'h0, msi_pulse}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R1 after release status", rd_data, 32'h0);

    // level mode
    step(1'b1, OFF_RAISE, 32'h0000_0005, 2'b00, 1'b0, "R2 R6 raise 5");
    step(1'b1, OFF_RAISE, 32'h0000_0030, 2'b00, 1'b0, "R2 raise or 30");
    idle(1'b0);
    step(1'b1, OFF_ACK,   32'h0000_0014, 2'b00, 1'b0, "R3 ack 14");
    step(1'b1, OFF_STAT,  32'hFFFF_FFFF, 2'b00, 1'b0, "R9 write to read offset");
    step(1'b1, 8'h68,     32'hFFFF_FFFF, 2'b00, 1'b0, "R9 write to unused offset");
    step(1'b0, OFF_RAISE, 32'h0000_00FF, 2'b00, 1'b0, "R9 raise without strobe");
    step(1'b0, OFF_ACK,   32'hFFFF_FFFF, 2'b00, 1'b0, "R9 ack without strobe");
    idle(1'b0);
    read_at(8'h60, 32'h0, "R9 read at raise offset");
    read_at(8'h00, 32'h0, "R9 read at offset 0");
    read_at(OFF_STAT, 32'h0000_0021, "R9 read at status offset");
    step(1'b0, 8'h00,     32'h0,         2'b01, 1'b0, "R5 event 0 sets 100");
    step(1'b1, OFF_ACK,   32'h0000_0100, 2'b01, 1'b0, "R4 event beats ack");
    step(1'b1, OFF_ACK,   32'hFFFF_FFFF, 2'b00, 1'b0, "R3 R6 ack all");
    step(1'b1, OFF_RAISE, 32'h8000_0000, 2'b11, 1'b0, "R5 raise with both events");
    step(1'b1, OFF_ACK,   32'h8000_0001, 2'b10, 1'b0, "R4 event 1 beats ack");
    step(1'b1, OFF_ACK,   32'hFFFF_FFFF, 2'b00, 1'b0, "R6 ack to zero");

    // message mode
    idle(1'b1);
    step(1'b1, OFF_RAISE, 32'h0000_0002, 2'b00, 1'b1, "R7 first raise pulses");
    step(1'b1, OFF_RAISE, 32'h0000_0004, 2'b00, 1'b1, "R7 raise while set no pulse");
    idle(1'b1);
    step(1'b1, OFF_ACK,   32'h0000_0002, 2'b00, 1'b1, "R8 partial ack");
    step(1'b1, OFF_ACK,   32'h0000_0004, 2'b00, 1'b1, "R8 ack to zero");
    step(1'b0, 8'h00,     32'h0,         2'b10, 1'b1, "R8 event repulses");
    step(1'b1, OFF_ACK,   32'h0000_0001, 2'b00, 1'b1, "R8 ack event bit");
    step(1'b1, OFF_RAISE, 32'h0000_0001, 2'b00, 1'b1, "R8 raise repulses");
    step(1'b1, OFF_ACK,   32'h0000_0001, 2'b00, 1'b1, "R8 ack again");

    // mode switch while set
    step(1'b1, OFF_RAISE, 32'h0000_0010, 2'b00, 1'b0, "R6 level raise");
    idle(1'b1);
    idle(1'b1);
    idle(1'b0);
    step(1'b1, OFF_ACK,   32'h0000_0010, 2'b00, 1'b0, "R6 level drop");
    idle(1'b0);
    idle(1'b0);
    repeat (2) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule